// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full `2*WIDTH`-bit product. The arithmetic is a square grid of identical bit cells. Each cell ANDs one bit of each operand and adds that product bit to a sum bit from the row above and a carry bit from its right neighbour. It passes its carry to the left and its sum downward. Every cell owns an output register. A cell in row `i`, column `j` therefore sits in pipeline stage `2*i + j`, so every cut through the grid runs along a diagonal. No path between registers crosses more than one full adder, whatever the operand width.

Operand bits reach later stages through short delay chains. Product bits that finish early are held back so that all `2*WIDTH` bits leave together. A valid flag travels in step with the data. Its per-stage copies act as load enables, so registers in empty stages keep their contents. A new operand pair can be issued on every clock, and there is no stall input. The fixed latency is `3*WIDTH - 2` cycles, which is 22 at the default width of 8, and is exposed as the localparam `LATENCY`.

Top module: `array_mult_pipe`

## Requirements
- R1: When `outValid` is high, `product` equals the unsigned product of the issuing `opA` and `opB`, expressed in 2*WIDTH bits.
- R2: An operand pair presented with `inValid` high in cycle c appears on `product`, with `outValid` high, in cycle c+LATENCY, where LATENCY = 3*WIDTH-2 (22 at WIDTH=8). In every other cycle `outValid` is low.
- R3: A new pair is accepted on every clock. Back-to-back pairs produce back-to-back results in issue order, and never more than LATENCY operations are in flight.
- R4: Operands presented while `inValid` is low are ignored and produce no result: the matching output cycle has `outValid` low, and after LATENCY consecutive idle input cycles `outValid` stays low.
- R5: `rst` is synchronous and active high. In the cycle after a reset edge `outValid` is low, and operations in flight at reset never produce a result.
- R6: Corner operands: any operand equal to zero gives 0, a factor of one returns the other operand, and all-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1 (65025 at WIDTH=8).
- R7: While `outValid` is high, `product` never exceeds (2^WIDTH - 1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Marks opA/opB as a new operation this cycle |
| opA | input | WIDTH | Multiplicand, unsigned |
| opB | input | WIDTH | Multiplier, unsigned |
| outValid | output | 1 | Marks product as the result of the pair issued LATENCY cycles earlier |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The assertions assume that reset is applied before the first operation and that `opA` and `opB` are known whenever `inValid` is high. They also assume that `inValid` is never unknown outside reset, because the in-flight and idle counters add it directly. The stimulus holds reset for several cycles at the start. It changes inputs only a fixed time after each rising edge and always drives defined values, zero operands included when a slot is idle. It inserts a mid-flight reset only while it also discards its own expected results.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;

  // Pipeline stage that a grid cell occupies: row weight counts twice
  // because the sum from the row above arrives from the diagonal neighbour.
  function automatic int cellStage(input int row, input int col);
    return 2 * row + col;
  endfunction

  // Total register count from operand ports to product port.
  function automatic int pipeLatency(input int width);
    return 3 * width - 2;
  endfunction

endpackage

// File: rtl/mp_delay.sv
module mp_delay #(
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic [DEPTH-1:0] en,
  input  logic             d,
  output logic             q
);

  logic [DEPTH-1:0] chain;

  // Each tap loads only when its own stage holds a live operation.
  always_ff @(posedge clk) begin
    if (en[0]) chain[0] <= d;
    for (int k = 1; k < DEPTH; k++) begin
      if (en[k]) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[DEPTH-1];

endmodule

// File: rtl/mp_cell.sv
module mp_cell (
  input  logic clk,
  input  logic en,
  input  logic aBit,
  input  logic bBit,
  input  logic sumIn,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);

  logic partial;
  logic sumNext;
  logic carryNext;

  always_comb begin
    partial   = aBit & bBit;
    sumNext   = partial ^ sumIn ^ carryIn;
    carryNext = (partial & sumIn) | (partial & carryIn) | (sumIn & carryIn);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sumOut   <= sumNext;
      carryOut <= carryNext;
    end
  end

endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl #(
  parameter int LAT = 22
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  output logic [LAT-1:0] stageEn,
  output logic           outValid
);

  localparam int CW = $clog2(LAT + 1) + 1;

  logic [LAT-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vPipe <= '0;
    end else begin
      vPipe[0] <= inValid;
      for (int k = 1; k < LAT; k++) vPipe[k] <= vPipe[k-1];
    end
  end

  // Stage s is busy when the operation issued s cycles ago was valid.
  always_comb begin
    stageEn[0] = inValid;
    for (int k = 1; k < LAT; k++) stageEn[k] = vPipe[k-1];
  end

  assign outValid = vPipe[LAT-1];

  // Assertion support: independent occupancy and idle-run counters.
  logic [CW-1:0] flightCnt;
  logic [CW-1:0] idleRun;
  logic          rstPrev;

  always_ff @(posedge clk) begin
    rstPrev <= rst;
    if (rst) begin
      flightCnt <= '0;
      idleRun   <= '0;
    end else begin
      flightCnt <= flightCnt + CW'(inValid) - CW'(outValid);
      if (inValid)                idleRun <= '0;
      else if (idleRun != CW'(LAT)) idleRun <= idleRun + 1'b1;
    end
  end

  AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    flightCnt <= CW'(LAT)); // R3

  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> flightCnt != '0); // R2

  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    idleRun == CW'(LAT) |-> !outValid); // R4

  always @(posedge clk) begin
    if (rstPrev) begin
      AST_RESET_QUIET: assert (!outValid); // R5
    end
  end

endmodule

// File: rtl/mp_array.sv
module mp_array #(
  parameter int W   = 8,
  parameter int LAT = 22
) (
  input  logic           clk,
  input  logic [LAT-1:0] stageEn,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [2*W-1:0] product
);

  import mulpipe_pkg::*;

  // Flattened grid nets, index row*W + col.
  logic [W*W-1:0] aTap;
  logic [W*W-1:0] bTap;
  logic [W*W-1:0] sumOut;
  logic [W*W-1:0] carryOut;
  logic [W-1:0]   topSum;

  // Multiplicand skew: bit j enters row 0 at stage j.
  for (genvar j = 0; j < W; j++) begin : g_aSkew
    if (j == 0) begin : g_direct
      assign aTap[0] = opA[0];
    end else begin : g_delay
      mp_delay #(.DEPTH(j)) uSkew (
        .clk(clk), .en(stageEn[j-1:0]), .d(opA[j]), .q(aTap[j])
      );
    end
  end

  // Multiplier skew: bit i enters column 0 of row i at stage 2i.
  for (genvar i = 0; i < W; i++) begin : g_bSkew
    if (i == 0) begin : g_direct
      assign bTap[0] = opB[0];
    end else begin : g_delay
      mp_delay #(.DEPTH(2*i)) uSkew (
        .clk(clk), .en(stageEn[2*i-1:0]), .d(opB[i]), .q(bTap[i*W])
      );
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_row
    // Top-of-row sum input: zero in row 0, delayed carry-out above otherwise.
    if (i == 0) begin : g_top0
      assign topSum[0] = 1'b0;
    end else begin : g_topN
      mp_delay #(.DEPTH(1)) uTop (
        .clk(clk),
        .en(stageEn[cellStage(i, W-2) : cellStage(i, W-2)]),
        .d(carryOut[(i-1)*W + W-1]),
        .q(topSum[i])
      );
    end

    for (genvar j = 0; j < W; j++) begin : g_col
      localparam int S = cellStage(i, j);
      logic sumIn;
      logic carryIn;

      if (i == 0)          begin : g_s0 assign sumIn = 1'b0;              end
      else if (j == W-1)   begin : g_sT assign sumIn = topSum[i];          end
      else                 begin : g_sD assign sumIn = sumOut[(i-1)*W + j+1]; end

      if (j == 0) begin : g_c0 assign carryIn = 1'b0;                  end
      else        begin : g_cR assign carryIn = carryOut[i*W + j-1];   end

      mp_cell uCell (
        .clk(clk), .en(stageEn[S]),
        .aBit(aTap[i*W + j]), .bBit(bTap[i*W + j]),
        .sumIn(sumIn), .carryIn(carryIn),
        .sumOut(sumOut[i*W + j]), .carryOut(carryOut[i*W + j])
      );

      // Multiplier bit moves one column right per stage.
      if (j < W-1) begin : g_bPass
        mp_delay #(.DEPTH(1)) uB (
          .clk(clk), .en(stageEn[S:S]), .d(bTap[i*W + j]), .q(bTap[i*W + j+1])
        );
      end
      // Multiplicand bit moves one row down every two stages.
      if (i < W-1) begin : g_aPass
        mp_delay #(.DEPTH(2)) uA (
          .clk(clk), .en(stageEn[S+1:S]), .d(aTap[i*W + j]), .q(aTap[(i+1)*W + j])
        );
      end
    end
  end

  // Deskew of low product bits, finished by column 0 of each early row.
  for (genvar k = 0; k < W-1; k++) begin : g_lowOut
    localparam int P = cellStage(k, 0) + 1;
    mp_delay #(.DEPTH(LAT-P)) uDeskew (
      .clk(clk), .en(stageEn[LAT-1:P]), .d(sumOut[k*W]), .q(product[k])
    );
  end

  // Deskew of the bits produced by the last row.
  for (genvar j = 0; j < W; j++) begin : g_highOut
    localparam int P = cellStage(W-1, j) + 1;
    if (j == W-1) begin : g_direct
      assign product[W-1+j] = sumOut[(W-1)*W + j];
    end else begin : g_delay
      mp_delay #(.DEPTH(LAT-P)) uDeskew (
        .clk(clk), .en(stageEn[LAT-1:P]), .d(sumOut[(W-1)*W + j]), .q(product[W-1+j])
      );
    end
  end

  assign product[2*W-1] = carryOut[W*W-1];

endmodule

// File: rtl/array_mult_pipe.sv
module array_mult_pipe #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);

  import mulpipe_pkg::*;

  localparam int LATENCY = pipeLatency(WIDTH);
  localparam logic [2*WIDTH-1:0] MAX_PROD =
    {{WIDTH{1'b0}}, {WIDTH{1'b1}}} * {{WIDTH{1'b0}}, {WIDTH{1'b1}}};

  logic [LATENCY-1:0] stageEn;

  mp_ctrl #(.LAT(LATENCY)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .stageEn(stageEn), .outValid(outValid)
  );

  mp_array #(.W(WIDTH), .LAT(LATENCY)) uArray (
    .clk(clk), .stageEn(stageEn), .opA(opA), .opB(opB), .product(product)
  );

  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> product <= MAX_PROD); // R7

endmodule

// File: tb/tb_array_mult_pipe.sv
module tb_array_mult_pipe;

  localparam int W   = 8;
  localparam int LAT = 3 * W - 2;

  // {opA, opB, expected product}
  localparam logic [31:0] VEC [0:11] = '{
    32'h0000_0000, 32'h0101_0001, 32'hFFFF_FE01, 32'hFF01_00FF,
    32'h01FF_00FF, 32'h00C8_0000, 32'h1010_0100, 32'h8002_0100,
    32'hAA55_3872, 32'h0D0B_008F, 32'hC864_4E20, 32'h6325_0E4F
  };

  typedef struct { logic [2*W-1:0] p; string tag; } exp_t;

  logic           clk = 0;
  logic           rst = 1;
  logic           inValid = 0;
  logic [W-1:0]   opA = '0;
  logic [W-1:0]   opB = '0;
  logic           outValid;
  logic [2*W-1:0] product;

  int   nChecks = 0;
  int   nErrors = 0;
  int   cyc = 0;
  bit   prevRst = 0;
  bit   done = 0;
  bit   vHist [0:4095];
  exp_t expQ [$];

  array_mult_pipe #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  always #10 clk = ~clk;

  task automatic drive(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
    exp_t e;
    @(posedge clk); #2;
    inValid = v; opA = a; opB = b;
    if (v && !rst) begin
      e.p = a * b; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic driveExp(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [2*W-1:0] p, input string tag);
    exp_t e;
    @(posedge clk); #2;
    inValid = 1; opA = a; opB = b;
    e.p = p; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic doReset(input int n);
    @(posedge clk); #2;
    rst = 1; inValid = 0; opA = '0; opB = '0;
    repeat (n) @(posedge clk);
    #2 rst = 0;
  endtask

  // Monitor: valid pattern (R2, R4), ordered data (R1, R3, R6), reset (R5).
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        if (prevRst) begin
          nChecks++;
          if (outValid !== 1'b0) begin
            nErrors++;
            $display("FAIL R5 outValid=%0d expected 0 during reset", outValid);
          end
        end
        cyc = 0;
        expQ.delete();
      end else begin
        bit expV;
        vHist[cyc % 4096] = inValid;
        expV = (cyc >= LAT) ? vHist[(cyc - LAT) % 4096] : 1'b0;
        nChecks++;
        if (outValid !== expV) begin
          nErrors++;
          $display("FAIL R2/R4 outValid=%0d expected %0d at cycle %0d", outValid, expV, cyc);
        end
        if (outValid === 1'b1) begin
          nChecks++;
          if (expQ.size() == 0) begin
            nErrors++;
            $display("FAIL R3 product=%0d expected no result", product);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            if (product !== e.p) begin
              nErrors++;
              $display("FAIL %s product=%0d expected %0d", e.tag, product, e.p);
            end
          end
        end
        cyc++;
      end
      prevRst = rst;
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nErrors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int k;
    doReset(4);

    // R1 R6 R3: table walked back to back
    for (int n = 0; n < 12; n++) begin
      driveExp(VEC[n][31:24], VEC[n][23:16], VEC[n][15:0], "R6");
    end
    for (int n = 0; n < LAT + 2; n++) drive(0, 8'hA5, 8'h5A, "R4");

    // R2: explicit latency count for a lone operation
    drive(1, 8'd7, 8'd9, "R1");
    k = 0;
    do begin
      drive(0, 8'd0, 8'd0, "R4");
      k++;
      #3;
    end while (outValid !== 1'b1 && k < 3 * LAT);
    nChecks++;
    if (k != LAT) begin
      nErrors++;
      $display("FAIL R2 latency=%0d expected %0d", k, LAT);
    end
    for (int n = 0; n < LAT + 2; n++) drive(0, 8'd0, 8'd0, "R4");

    // R4: random bubbles with junk operands on idle slots
    for (int n = 0; n < 150; n++) begin
      drive($urandom_range(0, 1) == 1, W'($urandom), W'($urandom), "R4");
    end

    // R3: dense back-to-back random stream
    for (int n = 0; n < 200; n++) drive(1, W'($urandom), W'($urandom), "R3");
    for (int n = 0; n < LAT + 2; n++) drive(0, 8'hFF, 8'hFF, "R4");

    // R5: reset with operations in flight; none may emerge afterwards
    for (int n = 0; n < 5; n++) drive(1, 8'hFF, 8'h80 + 8'(n), "R5");
    doReset(2);
    for (int n = 0; n < LAT + 4; n++) drive(0, 8'd0, 8'd0, "R5");

    // R6: corners again after reset
    driveExp(8'hFF, 8'hFF, 16'hFE01, "R6");
    driveExp(8'h00, 8'hFF, 16'h0000, "R6");
    driveExp(8'h01, 8'h9C, 16'h009C, "R6");
    for (int n = 0; n < LAT + 3; n++) drive(0, 8'd0, 8'd0, "R4");

    nChecks++;
    if (expQ.size() != 0) begin
      nErrors++;
      $display("FAIL R3 pending=%0d expected 0", expQ.size());
    end
    finishRun();
  end

endmodule